// File: doc/BRIEF.md
# Fourteen-Bit Instruction Decode and Execute Unit

This block takes one 14-bit instruction word for an 8-bit accumulator machine and works out what it does: which arithmetic or logic operation to run, which operand to use (the byte read from the file at the word's 7-bit address, or an 8-bit immediate carried in the word), and where the result goes (the working register W or back to the file). It also computes the new carry (C), digit carry (DC) and zero (Z) flags. For a conditional-test instruction it raises a request to skip the next instruction.

The surrounding core fetches the word, reads the file byte at address `instr_i[6:0]`, and presents both with the current W and flags while pulsing `issue_i`. One clock later the block presents the result, one write enable, the file address and the new flags, and the core applies them. Program flow, the call stack and peripherals belong to the core. Words that fall outside the handled groups, including the branch and return encodings, do nothing here.

Top module: `isa14_exec`

## Requirements
- R1: While `rst_n` is low, `w_we_o`, `f_we_o`, `skip_o`, `c_o`, `dc_o`, `z_o` and `result_o` are all 0.
- R2: A byte-group word has its opcode in bits 13:8, its destination bit d in bit 7 and its file address in bits 6:0. When d=0 the result goes to W (`w_we_o`=1). When d=1 it goes to the file at that address (`f_we_o`=1, `f_addr_o`=bits 6:0). The two enables are never high together.
- R3: Add (opcode 000111, file+W) and subtract (000010, file+~W+1) set C to the carry out of bit 7, where C=1 means no borrow on subtract. They set DC to the carry out of bit 3 and Z when the result is zero. Literal add (bits 13:9 = 11111) and literal subtract (bits 13:9 = 11110, immediate minus W) do the same with the immediate in place of the file byte, and write W.
- R4: AND 000101, OR 000100, XOR 000110 (each with W), complement 001001, decrement 000011, increment 001010 and move 001000 update only Z. C and DC pass through from `c_i` and `dc_i`.
- R5: Rotate left 001101 gives {f[6:0],C} with C taking f[7]. Rotate right 001100 gives {C,f[7:1]} with C taking f[0]. Only C changes.
- R6: Nibble swap 001110 gives {f[3:0],f[7:4]}. It and the two skip forms (decrement-skip 001011, increment-skip 001111) leave all three flags unchanged.
- R7: Bit clear (bits 13:10 = 0100) and bit set (0101) read the whole file byte, force only bit number bits 9:7 to 0 or 1, and write the full byte back to the file.
- R8: Increment-skip and decrement-skip assert `skip_o` exactly when their 8-bit result is zero.
- R9: Bit test-skip-if-clear (0110) and test-skip-if-set (0111) assert `skip_o` when the selected bit is 0 or 1 respectively. They write nothing.
- R10: Literal move (bits 13:10 = 1100) copies the immediate in bits 7:0 into W with no flag change. Literal OR (111000), AND (111001) and XOR (111010) combine the immediate with W, write W and update only Z.
- R11: Opcode 000001 writes zero to the file (bit 7=1) or to W (bit 7=0) and sets Z. Opcode 000000 with bit 7=1 writes W to the file with no flag change.
- R12: When a file write targets the status address (default 3, flags at C bit 0, DC bit 1, Z bit 2), each flag the instruction updates overrides its bit in the written byte. A flag the instruction does not update takes its value from the written byte. Clearing the status byte therefore writes 0x04.
- R13: Every other encoding (including opcode 000000 with bit 7=0, the 10xxxx group, 1101xx and 111011) writes nothing, requests no skip and leaves the flags unchanged.
- R14: Outputs reflect the word issued on the previous clock. A cycle with `issue_i` low yields no write enable and no skip on the next cycle, and the flags hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | Instruction word and operands are valid this cycle |
| instr_i | input | 14 | Instruction word |
| file_rd_i | input | 8 | Byte read from the file at instr_i[6:0] |
| w_i | input | 8 | Current working register |
| c_i | input | 1 | Current carry flag |
| dc_i | input | 1 | Current digit carry flag |
| z_i | input | 1 | Current zero flag |
| result_o | output | 8 | Result byte to write |
| w_we_o | output | 1 | Write result to W |
| f_we_o | output | 1 | Write result to the file |
| f_addr_o | output | 7 | File address for the write |
| c_o | output | 1 | New carry flag |
| dc_o | output | 1 | New digit carry flag |
| z_o | output | 1 | New zero flag |
| skip_o | output | 1 | Request to skip the next instruction |

## Verification
The block has one register stage, so any decode or datapath mistake appears at the ports on the cycle right after the word is issued. It can show as a wrong result byte, an enable on the wrong target, a flag that moved when it should have held, or a missing or spurious skip. A flag-mask error shows as early as one held flag differs from its input. A mistake in the status overlay shows only on writes to the status address, so those cases are driven on purpose. Every cycle is compared with a behavioural model that tracks the expected held flags across idle cycles.

// File: rtl/isa14_pkg.sv
package isa14_pkg;

  typedef enum logic [4:0] {
    OP_NOP, OP_ADD, OP_SUB, OP_AND, OP_IOR, OP_XOR, OP_COM, OP_INC,
    OP_DEC, OP_PASSA, OP_PASSW, OP_ZERO, OP_RLF, OP_RRF, OP_SWAP,
    OP_BCLR, OP_BSET
  } alu_op_e;

  typedef enum logic [1:0] {
    SK_NONE, SK_ZERO, SK_BITLO, SK_BITHI
  } skip_e;

  typedef struct packed {
    alu_op_e op;
    logic    use_lit;
    logic    wr_w;
    logic    wr_f;
    logic    upd_c;
    logic    upd_dc;
    logic    upd_z;
    skip_e   skip;
  } ctrl_t;

endpackage

// File: rtl/isa14_decode.sv
module isa14_decode
  import isa14_pkg::*;
#(
  parameter int IW = 14
) (
  input  logic [IW-1:0] instr,
  output ctrl_t         ctrl
);

  logic [5:0] opc;
  logic       dsel;

  assign opc  = instr[13:8];
  assign dsel = instr[7];

  // Fill in the common fields of a byte-group word whose target is picked by d.
  function automatic ctrl_t byte_op(alu_op_e op, logic d, logic uc, logic udc, logic uz, skip_e sk);
    ctrl_t c;
    c.op      = op;
    c.use_lit = 1'b0;
    c.wr_w    = ~d;
    c.wr_f    = d;
    c.upd_c   = uc;
    c.upd_dc  = udc;
    c.upd_z   = uz;
    c.skip    = sk;
    return c;
  endfunction

  function automatic ctrl_t lit_op(alu_op_e op, logic uc, logic udc, logic uz);
    ctrl_t c;
    c.op      = op;
    c.use_lit = 1'b1;
    c.wr_w    = 1'b1;
    c.wr_f    = 1'b0;
    c.upd_c   = uc;
    c.upd_dc  = udc;
    c.upd_z   = uz;
    c.skip    = SK_NONE;
    return c;
  endfunction

  always_comb begin
    ctrl = '{op: OP_NOP, use_lit: 1'b0, wr_w: 1'b0, wr_f: 1'b0,
             upd_c: 1'b0, upd_dc: 1'b0, upd_z: 1'b0, skip: SK_NONE};
    unique case (opc[5:4])
      2'b00: begin
        unique case (opc[3:0])
          4'b0000: if (dsel) ctrl = byte_op(OP_PASSW, 1'b1, 1'b0, 1'b0, 1'b0, SK_NONE);
          4'b0001: ctrl = byte_op(OP_ZERO, dsel, 1'b0, 1'b0, 1'b1, SK_NONE);
          4'b0010: ctrl = byte_op(OP_SUB,  dsel, 1'b1, 1'b1, 1'b1, SK_NONE);
          4'b0011: ctrl = byte_op(OP_DEC,  dsel, 1'b0, 1'b0, 1'b1, SK_NONE);
          4'b0100: ctrl = byte_op(OP_IOR,  dsel, 1'b0, 1'b0, 1'b1, SK_NONE);
          4'b0101: ctrl = byte_op(OP_AND,  dsel, 1'b0, 1'b0, 1'b1, SK_NONE);
          4'b0110: ctrl = byte_op(OP_XOR,  dsel, 1'b0, 1'b0, 1'b1, SK_NONE);
          4'b0111: ctrl = byte_op(OP_ADD,  dsel, 1'b1, 1'b1, 1'b1, SK_NONE);
          4'b1000: ctrl = byte_op(OP_PASSA, dsel, 1'b0, 1'b0, 1'b1, SK_NONE);
          4'b1001: ctrl = byte_op(OP_COM,  dsel, 1'b0, 1'b0, 1'b1, SK_NONE);
          4'b1010: ctrl = byte_op(OP_INC,  dsel, 1'b0, 1'b0, 1'b1, SK_NONE);
          4'b1011: ctrl = byte_op(OP_DEC,  dsel, 1'b0, 1'b0, 1'b0, SK_ZERO);
          4'b1100: ctrl = byte_op(OP_RRF,  dsel, 1'b1, 1'b0, 1'b0, SK_NONE);
          4'b1101: ctrl = byte_op(OP_RLF,  dsel, 1'b1, 1'b0, 1'b0, SK_NONE);
          4'b1110: ctrl = byte_op(OP_SWAP, dsel, 1'b0, 1'b0, 1'b0, SK_NONE);
          default: ctrl = byte_op(OP_INC,  dsel, 1'b0, 1'b0, 1'b0, SK_ZERO);
        endcase
      end
      2'b01: begin
        unique case (opc[3:2])
          2'b00:   ctrl = byte_op(OP_BCLR, 1'b1, 1'b0, 1'b0, 1'b0, SK_NONE);
          2'b01:   ctrl = byte_op(OP_BSET, 1'b1, 1'b0, 1'b0, 1'b0, SK_NONE);
          2'b10: begin
            ctrl.op   = OP_PASSA;
            ctrl.skip = SK_BITLO;
          end
          default: begin
            ctrl.op   = OP_PASSA;
            ctrl.skip = SK_BITHI;
          end
        endcase
      end
      2'b11: begin
        unique case (opc[3:2])
          2'b00: ctrl = lit_op(OP_PASSA, 1'b0, 1'b0, 1'b0);
          2'b10: begin
            unique case (opc[1:0])
              2'b00:   ctrl = lit_op(OP_IOR, 1'b0, 1'b0, 1'b1);
              2'b01:   ctrl = lit_op(OP_AND, 1'b0, 1'b0, 1'b1);
              2'b10:   ctrl = lit_op(OP_XOR, 1'b0, 1'b0, 1'b1);
              default: ;
            endcase
          end
          2'b11: ctrl = lit_op(opc[1] ? OP_ADD : OP_SUB, 1'b1, 1'b1, 1'b1);
          default: ;
        endcase
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/isa14_alu.sv
module isa14_alu
  import isa14_pkg::*;
#(
  parameter int DW = 8,
  localparam int BW = $clog2(DW),
  localparam int HW = DW / 2
) (
  input  alu_op_e       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] w,
  input  logic [BW-1:0] bsel,
  input  logic          c_in,
  output logic [DW-1:0] res,
  output logic          c_out,
  output logic          dc_out,
  output logic          bit_val
);

  logic [DW:0]   sum;
  logic [HW:0]   nib;
  logic [DW-1:0] b_eff;
  logic          cin_eff;
  logic [DW-1:0] onehot;

  // Shared adder: subtraction uses the inverted W plus one.
  always_comb begin
    b_eff   = (op == OP_SUB) ? ~w : w;
    cin_eff = (op == OP_SUB);
    sum     = {1'b0, a} + {1'b0, b_eff} + {{DW{1'b0}}, cin_eff};
    nib     = {1'b0, a[HW-1:0]} + {1'b0, b_eff[HW-1:0]} + {{HW{1'b0}}, cin_eff};
  end

  assign onehot  = {{(DW-1){1'b0}}, 1'b1} << bsel;
  assign bit_val = a[bsel];

  always_comb begin
    res    = '0;
    c_out  = sum[DW];
    dc_out = nib[HW];
    unique case (op)
      OP_ADD, OP_SUB: res = sum[DW-1:0];
      OP_AND:   res = a & w;
      OP_IOR:   res = a | w;
      OP_XOR:   res = a ^ w;
      OP_COM:   res = ~a;
      OP_INC:   res = a + {{(DW-1){1'b0}}, 1'b1};
      OP_DEC:   res = a - {{(DW-1){1'b0}}, 1'b1};
      OP_PASSA: res = a;
      OP_PASSW: res = w;
      OP_ZERO:  res = '0;
      OP_RLF: begin
        res   = {a[DW-2:0], c_in};
        c_out = a[DW-1];
      end
      OP_RRF: begin
        res   = {c_in, a[DW-1:1]};
        c_out = a[0];
      end
      OP_SWAP:  res = {a[HW-1:0], a[DW-1:HW]};
      OP_BCLR:  res = a & ~onehot;
      OP_BSET:  res = a | onehot;
      default:  res = '0;
    endcase
  end

endmodule

// File: rtl/isa14_exec.sv
module isa14_exec
  import isa14_pkg::*;
#(
  parameter int              DW          = 8,
  parameter int              AW          = 7,
  parameter logic [AW-1:0]   STATUS_ADDR = 7'h03,
  parameter int              C_POS       = 0,
  parameter int              DC_POS      = 1,
  parameter int              Z_POS       = 2,
  localparam int             IW          = 14,
  localparam int             BW          = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue_i,
  input  logic [IW-1:0] instr_i,
  input  logic [DW-1:0] file_rd_i,
  input  logic [DW-1:0] w_i,
  input  logic          c_i,
  input  logic          dc_i,
  input  logic          z_i,
  output logic [DW-1:0] result_o,
  output logic          w_we_o,
  output logic          f_we_o,
  output logic [AW-1:0] f_addr_o,
  output logic          c_o,
  output logic          dc_o,
  output logic          z_o,
  output logic          skip_o
);

  ctrl_t         ctrl;
  logic [DW-1:0] opnd_a;
  logic [DW-1:0] alu_res;
  logic          alu_c, alu_dc, bit_val;
  logic          status_hit;
  logic [DW-1:0] res_nx;
  logic          c_nx, dc_nx, z_nx, skip_nx;
  logic          res_zero;

  isa14_decode #(.IW(IW)) u_dec (
    .instr (instr_i),
    .ctrl  (ctrl)
  );

  assign opnd_a = ctrl.use_lit ? instr_i[DW-1:0] : file_rd_i;

  isa14_alu #(.DW(DW)) u_alu (
    .op      (ctrl.op),
    .a       (opnd_a),
    .w       (w_i),
    .bsel    (instr_i[AW+BW-1:AW]),
    .c_in    (c_i),
    .res     (alu_res),
    .c_out   (alu_c),
    .dc_out  (alu_dc),
    .bit_val (bit_val)
  );

  assign res_zero   = (alu_res == '0);
  assign status_hit = ctrl.wr_f && (instr_i[AW-1:0] == STATUS_ADDR);

  // Flag selection and status-byte overlay.
  always_comb begin
    res_nx = alu_res;
    c_nx   = ctrl.upd_c  ? alu_c    : (status_hit ? alu_res[C_POS]  : c_i);
    dc_nx  = ctrl.upd_dc ? alu_dc   : (status_hit ? alu_res[DC_POS] : dc_i);
    z_nx   = ctrl.upd_z  ? res_zero : (status_hit ? alu_res[Z_POS]  : z_i);
    if (status_hit) begin
      res_nx[C_POS]  = c_nx;
      res_nx[DC_POS] = dc_nx;
      res_nx[Z_POS]  = z_nx;
    end
    unique case (ctrl.skip)
      SK_ZERO:  skip_nx = res_zero;
      SK_BITLO: skip_nx = ~bit_val;
      SK_BITHI: skip_nx = bit_val;
      default:  skip_nx = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_o <= '0;
      w_we_o   <= 1'b0;
      f_we_o   <= 1'b0;
      f_addr_o <= '0;
      c_o      <= 1'b0;
      dc_o     <= 1'b0;
      z_o      <= 1'b0;
      skip_o   <= 1'b0;
    end else begin
      w_we_o <= issue_i & ctrl.wr_w;
      f_we_o <= issue_i & ctrl.wr_f;
      skip_o <= issue_i & skip_nx;
      if (issue_i) begin
        result_o <= res_nx;
        f_addr_o <= instr_i[AW-1:0];
        c_o      <= c_nx;
        dc_o     <= dc_nx;
        z_o      <= z_nx;
      end
    end
  end

  // R2: a result has one destination only.
  p_one_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(w_we_o && f_we_o));

  // R14: an idle cycle produces no action and holds the flags.
  p_idle_quiet_r14: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_i |=> (!w_we_o && !f_we_o && !skip_o && $stable({c_o, dc_o, z_o})));

  // R11: both clear forms leave Z set.
  p_clear_sets_z_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && instr_i[13:8] == 6'b000001) |=> z_o);

  // R9: bit tests never write.
  p_test_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && instr_i[13:11] == 3'b011) |=> (!w_we_o && !f_we_o));

  // R13: the branch group does nothing and passes the flags through.
  p_branch_nop_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && instr_i[13:12] == 2'b10) |=>
      (!w_we_o && !f_we_o && !skip_o &&
       c_o == $past(c_i) && dc_o == $past(dc_i) && z_o == $past(z_i)));

endmodule

// File: tb/isa14_exec_tb.sv
module isa14_exec_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        issue_i;
  logic [13:0] instr_i;
  logic [7:0]  file_rd_i, w_i;
  logic        c_i, dc_i, z_i;
  logic [7:0]  result_o;
  logic        w_we_o, f_we_o, c_o, dc_o, z_o, skip_o;
  logic [6:0]  f_addr_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  isa14_exec u_dut (
    .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .instr_i(instr_i),
    .file_rd_i(file_rd_i), .w_i(w_i), .c_i(c_i), .dc_i(dc_i), .z_i(z_i),
    .result_o(result_o), .w_we_o(w_we_o), .f_we_o(f_we_o), .f_addr_o(f_addr_o),
    .c_o(c_o), .dc_o(dc_o), .z_o(z_o), .skip_o(skip_o)
  );

  // Expected state carried across cycles.
  logic e_c = 0, e_dc = 0, e_z = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Behavioural model of one issued word.
  task automatic model(input logic [13:0] i, input int f, input int w,
                       input logic c, input logic dc, input logic z,
                       output int r, output bit wwe, output bit fwe,
                       output logic nc, output logic ndc, output logic nz, output bit sk);
    int k, b, t;
    bit uc, udc, uz, d;
    r = 0; wwe = 0; fwe = 0; sk = 0; uc = 0; udc = 0; uz = 0;
    nc = c; ndc = dc; nz = z;
    d = i[7]; k = int'(i[7:0]); b = int'(i[9:7]);
    if (i[13:12] == 2'b00) begin
      fwe = d; wwe = !d;
      case (int'(i[11:8]))
        0:  begin wwe = 0; fwe = d; r = w; end
        1:  begin r = 0; uz = 1; end
        2:  begin r = (f - w) & 255; nc = f >= w; ndc = (f % 16) >= (w % 16); uc = 1; udc = 1; uz = 1; end
        3:  begin r = (f + 255) & 255; uz = 1; end
        4:  begin r = f | w; uz = 1; end
        5:  begin r = f & w; uz = 1; end
        6:  begin r = f ^ w; uz = 1; end
        7:  begin r = (f + w) & 255; nc = (f + w) > 255; ndc = (f % 16 + w % 16) > 15; uc = 1; udc = 1; uz = 1; end
        8:  begin r = f; uz = 1; end
        9:  begin r = 255 - f; uz = 1; end
        10: begin r = (f + 1) & 255; uz = 1; end
        11: begin r = (f + 255) & 255; sk = (r == 0); end
        12: begin r = (f / 2) + (c ? 128 : 0); nc = f[0]; uc = 1; end
        13: begin r = ((f * 2) & 255) + (c ? 1 : 0); nc = f[7]; uc = 1; end
        14: begin r = ((f % 16) * 16) + (f / 16); end
        default: begin r = (f + 1) & 255; sk = (r == 0); end
      endcase
    end else if (i[13:12] == 2'b01) begin
      t = (f >> b) & 1;
      case (int'(i[11:10]))
        0: begin r = f & ~(1 << b) & 255; fwe = 1; end
        1: begin r = f | (1 << b); fwe = 1; end
        2: sk = (t == 0);
        default: sk = (t == 1);
      endcase
    end else if (i[13:12] == 2'b11) begin
      if (i[11:10] == 2'b00) begin r = k; wwe = 1; end
      else if (i[11:8] == 4'b1000) begin r = k | w; wwe = 1; uz = 1; end
      else if (i[11:8] == 4'b1001) begin r = k & w; wwe = 1; uz = 1; end
      else if (i[11:8] == 4'b1010) begin r = k ^ w; wwe = 1; uz = 1; end
      else if (i[11:9] == 3'b111) begin
        r = (k + w) & 255; nc = (k + w) > 255; ndc = (k % 16 + w % 16) > 15;
        wwe = 1; uc = 1; udc = 1; uz = 1;
      end else if (i[11:9] == 3'b110) begin
        r = (k - w) & 255; nc = k >= w; ndc = (k % 16) >= (w % 16);
        wwe = 1; uc = 1; udc = 1; uz = 1;
      end
    end
    if (uz) nz = (r == 0);
    if (fwe && i[6:0] == 7'd3) begin
      if (uc) r = (r & ~1) | (nc ? 1 : 0); else nc = r[0];
      if (udc) r = (r & ~2) | (ndc ? 2 : 0); else ndc = r[1];
      if (uz) r = (r & ~4) | (nz ? 4 : 0); else nz = r[2];
    end
  endtask

  task automatic step(input bit iss, input logic [13:0] i, input int f, input int w,
                      input logic c, input logic dc, input logic z, input string tag);
    int r; bit wwe, fwe, sk; logic nc, ndc, nz;
    @(negedge clk);
    issue_i = iss; instr_i = i; file_rd_i = f[7:0]; w_i = w[7:0];
    c_i = c; dc_i = dc; z_i = z;
    model(i, f, w, c, dc, z, r, wwe, fwe, nc, ndc, nz, sk);
    if (!iss) begin wwe = 0; fwe = 0; sk = 0; end
    else begin e_c = nc; e_dc = ndc; e_z = nz; end
    @(posedge clk); #1;
    chk(tag, "w_we", int'(w_we_o), int'(wwe));
    chk(tag, "f_we", int'(f_we_o), int'(fwe));
    chk(tag, "skip", int'(skip_o), int'(sk));
    chk(tag, "flags", int'({c_o, dc_o, z_o}), int'({e_c, e_dc, e_z}));
    if (wwe || fwe) chk(tag, "result", int'(result_o), r);
    if (fwe) chk(tag, "f_addr", int'(f_addr_o), int'(i[6:0]));
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    if (!done) begin
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; issue_i = 0; instr_i = 0; file_rd_i = 0; w_i = 0;
    c_i = 1; dc_i = 1; z_i = 1;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1", "enables", int'({w_we_o, f_we_o, skip_o}), 0);
    chk("R1", "flags", int'({c_o, dc_o, z_o}), 0);
    chk("R1", "result", int'(result_o), 0);
    @(negedge clk); rst_n = 1;

    // R2 destination select
    step(1, {6'b000111, 1'b0, 7'h20}, 8'h10, 8'h05, 0, 0, 0, "R2");
    step(1, {6'b000111, 1'b1, 7'h21}, 8'h10, 8'h05, 0, 0, 0, "R2");
    // R3 add/sub flags
    step(1, {6'b000111, 1'b0, 7'h22}, 8'hF8, 8'h08, 0, 0, 0, "R3");
    step(1, {6'b000111, 1'b0, 7'h22}, 8'h0F, 8'h01, 1, 0, 1, "R3");
    step(1, {6'b000010, 1'b0, 7'h22}, 8'h05, 8'h05, 0, 0, 0, "R3");
    step(1, {6'b000010, 1'b1, 7'h22}, 8'h03, 8'h05, 1, 1, 1, "R3");
    step(1, {6'b000010, 1'b0, 7'h22}, 8'h20, 8'h01, 0, 0, 0, "R3");
    step(1, {6'b111110, 8'h10}, 0, 8'h30, 0, 0, 0, "R3");
    step(1, {6'b111100, 8'h10}, 0, 8'h30, 1, 1, 1, "R3");
    step(1, {6'b111101, 8'hFF}, 0, 8'h01, 0, 0, 0, "R3");
    // R4 Z-only ops
    step(1, {6'b000101, 1'b0, 7'h30}, 8'hF0, 8'h0F, 1, 1, 0, "R4");
    step(1, {6'b000100, 1'b0, 7'h30}, 8'hF0, 8'h0F, 0, 1, 1, "R4");
    step(1, {6'b000110, 1'b1, 7'h30}, 8'hAA, 8'hAA, 1, 0, 0, "R4");
    step(1, {6'b001001, 1'b0, 7'h30}, 8'hFF, 8'h00, 1, 1, 0, "R4");
    step(1, {6'b000011, 1'b0, 7'h30}, 8'h01, 8'h00, 0, 1, 0, "R4");
    step(1, {6'b001010, 1'b1, 7'h30}, 8'hFF, 8'h00, 1, 0, 0, "R4");
    step(1, {6'b001000, 1'b0, 7'h30}, 8'h00, 8'h55, 1, 1, 0, "R4");
    // R5 rotates
    step(1, {6'b001101, 1'b0, 7'h31}, 8'h81, 8'h00, 0, 1, 1, "R5");
    step(1, {6'b001101, 1'b1, 7'h31}, 8'h40, 8'h00, 1, 0, 0, "R5");
    step(1, {6'b001100, 1'b0, 7'h31}, 8'h01, 8'h00, 1, 0, 1, "R5");
    step(1, {6'b001100, 1'b0, 7'h31}, 8'h02, 8'h00, 0, 1, 0, "R5");
    // R6 swap and flag-neutral ops
    step(1, {6'b001110, 1'b0, 7'h32}, 8'hA5, 8'h00, 1, 0, 1, "R6");
    step(1, {6'b001110, 1'b1, 7'h32}, 8'h00, 8'h00, 0, 1, 0, "R6");
    // R8 skip on zero
    step(1, {6'b001011, 1'b1, 7'h33}, 8'h01, 8'h00, 1, 1, 0, "R8");
    step(1, {6'b001011, 1'b0, 7'h33}, 8'h02, 8'h00, 0, 0, 1, "R8");
    step(1, {6'b001111, 1'b0, 7'h33}, 8'hFF, 8'h00, 0, 1, 0, "R8");
    step(1, {6'b001111, 1'b1, 7'h33}, 8'h7F, 8'h00, 1, 0, 1, "R8");
    // R7 bit set/clear
    step(1, {4'b0100, 3'd5, 7'h40}, 8'hFF, 8'h00, 0, 0, 0, "R7");
    step(1, {4'b0101, 3'd0, 7'h40}, 8'h80, 8'h00, 1, 1, 1, "R7");
    step(1, {4'b0101, 3'd7, 7'h41}, 8'h80, 8'h00, 0, 0, 0, "R7");
    // R9 bit tests
    step(1, {4'b0110, 3'd3, 7'h42}, 8'hF7, 8'h00, 0, 0, 0, "R9");
    step(1, {4'b0110, 3'd3, 7'h42}, 8'h08, 8'h00, 0, 0, 0, "R9");
    step(1, {4'b0111, 3'd6, 7'h42}, 8'h40, 8'h00, 1, 0, 1, "R9");
    step(1, {4'b0111, 3'd6, 7'h42}, 8'hBF, 8'h00, 1, 0, 1, "R9");
    // R10 literal ops
    step(1, {6'b110010, 8'h5A}, 0, 8'h00, 1, 1, 1, "R10");
    step(1, {6'b111000, 8'h00}, 0, 8'h00, 0, 0, 0, "R10");
    step(1, {6'b111001, 8'h0F}, 0, 8'hF3, 1, 1, 1, "R10");
    step(1, {6'b111010, 8'h3C}, 0, 8'h3C, 0, 0, 0, "R10");
    // R11 clears and move W to file
    step(1, {6'b000001, 1'b1, 7'h50}, 8'h77, 8'h11, 1, 1, 0, "R11");
    step(1, {6'b000001, 1'b0, 7'h50}, 8'h77, 8'h11, 0, 0, 0, "R11");
    step(1, {6'b000000, 1'b1, 7'h51}, 8'h77, 8'h00, 0, 1, 0, "R11");
    // R12 status overlay
    step(1, {6'b000001, 1'b1, 7'h03}, 8'hFF, 8'h00, 1, 1, 0, "R12");
    step(1, {6'b001110, 1'b1, 7'h03}, 8'h50, 8'h00, 0, 0, 0, "R12");
    step(1, {6'b000111, 1'b1, 7'h03}, 8'hF0, 8'h20, 0, 0, 1, "R12");
    step(1, {4'b0101, 3'd0, 7'h03}, 8'h00, 8'h00, 0, 1, 1, "R12");
    step(1, {6'b001101, 1'b1, 7'h03}, 8'h07, 8'h00, 1, 0, 0, "R12");
    // R13 reserved / no-op encodings
    step(1, {6'b000000, 1'b0, 7'h08}, 8'h12, 8'h34, 1, 0, 1, "R13");
    step(1, 14'b10_0000_0000_0001, 8'h12, 8'h34, 0, 1, 0, "R13");
    step(1, 14'b10_1111_1111_1111, 8'h12, 8'h34, 1, 1, 1, "R13");
    step(1, {6'b110100, 8'h44}, 8'h12, 8'h34, 0, 0, 1, "R13");
    step(1, {6'b111011, 8'h44}, 8'h12, 8'h34, 1, 0, 0, "R13");
    // R14 idle cycles hold flags
    step(0, {6'b000001, 1'b1, 7'h50}, 8'h00, 8'h00, 0, 0, 0, "R14");
    step(0, {6'b001111, 1'b1, 7'h50}, 8'hFF, 8'h00, 1, 1, 1, "R14");

    // Mixed random stream
    for (int n = 0; n < 1500; n++) begin
      logic [13:0] ri;
      ri = 14'($urandom);
      if ($urandom_range(0, 5) == 0) ri[6:0] = 7'd3;
      step(($urandom_range(0, 4) != 0), ri, int'($urandom_range(0, 255)),
           int'($urandom_range(0, 255)), 1'($urandom), 1'($urandom), 1'($urandom), "R14");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule